// File: doc/BRIEF.md
# Receive DMA Request Scheduler

This block picks which receive channel next owns the shared host bus to move packet data from its channel FIFO into host memory. Every channel reports its FIFO fill level, its configured transfer size (in blocks), a start-of-packet flag, an end-of-packet flag, a priority bit and a write strobe for incoming serial data. When a channel's level reaches its transfer size the request is captured. The scheduler then grants one whole transaction series at a time and steps the DMA datapath through that series with a step code and a per-transaction handshake.

Three tiers compete, strongest first: refilling the on-chip cache of free buffer references, channels whose priority bit is set, and all remaining channels. Within each channel tier the channels take turns. A granted series is never broken up by another receive channel. The transmit side may still claim the bus in the gap after any single transaction, and hands it back with a completion pulse. The block also flags an overrun when serial data arrives for a channel whose FIFO is already full.

Top module: `rxdma_sched`

## Requirements
- R1: A channel's request is captured at the clock edge where its level is at least its transfer size and it is not the channel in service. The request stays captured, even if the level falls again, until that channel is granted.
- R2: When the scheduler is idle and several sources wait, it grants the cache refill first (series code 1, step code 1). Next come captured channels with the priority bit set, and last the other captured channels. A refill grant reports channel 0.
- R3: Inside one tier, the search starts at the channel after the last one whose series completed in that tier, and wraps around. The tier's pointer moves only when a series completes.
- R4: A start series (code 2) is chosen when the granted channel has the start flag and not the end flag. It runs reference fetch (step 2), descriptor read (step 3) and data write (step 4). The fetch step appears only on the first start series after reset and on every sixth one after that. The others begin at step 3.
- R5: An end series (code 4) runs final data write (step 5), descriptor write (step 6) and reference post (step 7). The grant is released at the edge where step 7 completes.
- R6: The end flag takes precedence over the start flag. A channel with neither flag gets a body series (code 3) made of a single data write (step 4).
- R7: While a series is in progress, the granted channel and series code do not change. No other receive channel is granted until the series ends.
- R8: If the transmit request is high when a transaction that is not the last of its series completes, the transmit grant is raised and the transaction valid is held low. The next step code is already presented. The transaction valid returns one cycle after the transmit done pulse. A transmit grant never appears outside such a gap.
- R9: One cycle after a data strobe for a channel whose level equals the full FIFO depth, that channel's overrun bit pulses high. A strobe below full depth gives no pulse.
- R10: In reset and while idle, the grant valid, transaction valid, transmit grant and overrun outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_i | input | NCH*LW | Per-channel FIFO fill level in blocks |
| xfer_i | input | NCH*LW | Per-channel transfer size in blocks |
| sop_i | input | NCH | Per-channel start-of-packet flag |
| eop_i | input | NCH | Per-channel end-of-packet flag |
| prio_i | input | NCH | Per-channel priority bit |
| wr_i | input | NCH | Per-channel incoming data strobe |
| refill_req_i | input | 1 | Free-reference cache refill request |
| txn_done_i | input | 1 | Current transaction completed |
| tx_req_i | input | 1 | Transmit side asks for a slot between transactions |
| tx_done_i | input | 1 | Transmit side finished its slot |
| gnt_valid_o | output | 1 | A series is granted |
| gnt_ch_o | output | CW | Granted channel |
| seq_o | output | 3 | Series code |
| step_o | output | 3 | Current step code |
| txn_valid_o | output | 1 | Datapath should run the current step |
| tx_gnt_o | output | 1 | Transmit side owns the bus |
| ovr_o | output | NCH | Per-channel overrun pulse |

## Verification
Table vectors come from a fresh reset each time. They try single requests, a refill racing channel requests, priority against normal channels, and mixed start and end flags. Together these separate tier order from turn order and series selection. Directed runs keep all four channels requesting, so that rotation order and the moment the pointer moves are visible. They also repeat start series on one channel to locate the sixth-start fetch. One run raises a transmit request and a one-cycle rival request in the middle of a series; this shows whether atomicity, the interleave gap and request holding are implemented or only appear to be. Overrun is driven both at full depth and one block below it.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_CACHE = 3'd1,
        SEQ_SOP   = 3'd2,
        SEQ_BODY  = 3'd3,
        SEQ_EOP   = 3'd4
    } seq_e;

    typedef enum logic [2:0] {
        STP_NONE       = 3'd0,
        STP_CACHE_FILL = 3'd1,
        STP_REF_FETCH  = 3'd2,
        STP_DESC_RD    = 3'd3,
        STP_DATA_WR    = 3'd4,
        STP_TAIL_WR    = 3'd5,
        STP_DESC_WR    = 3'd6,
        STP_REF_POST   = 3'd7
    } step_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_RUN  = 2'd1,
        FS_GAP  = 2'd2
    } fsm_e;

    function automatic logic step_is_last(step_e s);
        return (s == STP_CACHE_FILL) || (s == STP_DATA_WR) || (s == STP_REF_POST);
    endfunction

    function automatic step_e step_after(step_e s);
        case (s)
            STP_REF_FETCH: return STP_DESC_RD;
            STP_DESC_RD:   return STP_DATA_WR;
            STP_TAIL_WR:   return STP_DESC_WR;
            STP_DESC_WR:   return STP_REF_POST;
            default:       return STP_NONE;
        endcase
    endfunction

    function automatic step_e step_first(seq_e q, logic with_fetch);
        case (q)
            SEQ_CACHE: return STP_CACHE_FILL;
            SEQ_SOP:   return with_fetch ? STP_REF_FETCH : STP_DESC_RD;
            SEQ_BODY:  return STP_DATA_WR;
            SEQ_EOP:   return STP_TAIL_WR;
            default:   return STP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rxs_req_latch.sv
module rxs_req_latch #(
    parameter int FIFO_BLKS = 15,
    parameter int LW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] lvl,
    input  logic [LW-1:0] xfer,
    input  logic          wr,
    input  logic          busy,
    input  logic          take,
    output logic          pend,
    output logic          ovr
);
    localparam logic [LW-1:0] FULL = LW'(FIFO_BLKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (take)
                pend <= 1'b0;
            else if (!busy && (lvl >= xfer))
                pend <= 1'b1;
            ovr <= wr && (lvl == FULL);
        end
    end
endmodule

// File: rtl/rxs_rr_arb.sv
module rxs_rr_arb #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          adv,
    input  logic [CW-1:0] adv_idx,
    output logic          hit,
    output logic [CW-1:0] idx
);
    logic [CW-1:0] ptr;

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!hit && req[j]) begin
                hit = 1'b1;
                idx = CW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= (int'(adv_idx) == N - 1) ? '0 : adv_idx + 1'b1;
    end
endmodule

// File: rtl/rxs_seq_fsm.sv
module rxs_seq_fsm
    import rxs_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int CW           = 2,
    parameter int REFILL_EVERY = 6,
    localparam int SW = (REFILL_EVERY > 1) ? $clog2(REFILL_EVERY) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           refill_req,
    input  logic           p_hit,
    input  logic [CW-1:0]  p_idx,
    input  logic           n_hit,
    input  logic [CW-1:0]  n_idx,
    input  logic [NCH-1:0] sop,
    input  logic [NCH-1:0] eop,
    input  logic           txn_done,
    input  logic           tx_req,
    input  logic           tx_done,
    output logic           active,
    output logic [CW-1:0]  gnt_ch,
    output seq_e           seq,
    output step_e          step,
    output logic           txn_valid,
    output logic           tx_gnt,
    output logic           take,
    output logic [CW-1:0]  take_ch,
    output logic           fin,
    output logic           fin_prio
);
    fsm_e          st;
    logic          tier_prio;
    logic [SW-1:0] sop_cnt;
    seq_e          pick_seq;

    assign active    = (st != FS_IDLE);
    assign txn_valid = (st == FS_RUN);
    assign tx_gnt    = (st == FS_GAP);
    assign take      = (st == FS_IDLE) && !refill_req && (p_hit || n_hit);
    assign take_ch   = p_hit ? p_idx : n_idx;
    assign fin       = (st == FS_RUN) && txn_done && step_is_last(step) && (seq != SEQ_CACHE);
    assign fin_prio  = tier_prio;

    always_comb begin
        if (eop[take_ch])
            pick_seq = SEQ_EOP;
        else if (sop[take_ch])
            pick_seq = SEQ_SOP;
        else
            pick_seq = SEQ_BODY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FS_IDLE;
            gnt_ch    <= '0;
            seq       <= SEQ_IDLE;
            step      <= STP_NONE;
            tier_prio <= 1'b0;
            sop_cnt   <= '0;
        end else begin
            case (st)
                FS_IDLE: begin
                    if (refill_req) begin
                        st     <= FS_RUN;
                        gnt_ch <= '0;
                        seq    <= SEQ_CACHE;
                        step   <= step_first(SEQ_CACHE, 1'b0);
                    end else if (take) begin
                        st        <= FS_RUN;
                        gnt_ch    <= take_ch;
                        tier_prio <= p_hit;
                        seq       <= pick_seq;
                        step      <= step_first(pick_seq, sop_cnt == '0);
                        if (pick_seq == SEQ_SOP)
                            sop_cnt <= (int'(sop_cnt) == REFILL_EVERY - 1) ? '0 : sop_cnt + 1'b1;
                    end
                end
                FS_RUN: begin
                    if (txn_done) begin
                        if (step_is_last(step)) begin
                            st   <= FS_IDLE;
                            seq  <= SEQ_IDLE;
                            step <= STP_NONE;
                        end else begin
                            step <= step_after(step);
                            st   <= tx_req ? FS_GAP : FS_RUN;
                        end
                    end
                end
                FS_GAP: begin
                    if (tx_done)
                        st <= FS_RUN;
                end
                default: st <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxdma_sched.sv
module rxdma_sched
    import rxs_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int FIFO_BLKS    = 15,
    parameter int REFILL_EVERY = 6,
    localparam int LW = $clog2(FIFO_BLKS + 1),
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH*LW-1:0] lvl_i,
    input  logic [NCH*LW-1:0] xfer_i,
    input  logic [NCH-1:0]    sop_i,
    input  logic [NCH-1:0]    eop_i,
    input  logic [NCH-1:0]    prio_i,
    input  logic [NCH-1:0]    wr_i,
    input  logic              refill_req_i,
    input  logic              txn_done_i,
    input  logic              tx_req_i,
    input  logic              tx_done_i,
    output logic              gnt_valid_o,
    output logic [CW-1:0]     gnt_ch_o,
    output logic [2:0]        seq_o,
    output logic [2:0]        step_o,
    output logic              txn_valid_o,
    output logic              tx_gnt_o,
    output logic [NCH-1:0]    ovr_o
);
    logic [NCH-1:0] pend;
    logic           active, take, fin, fin_prio;
    logic [CW-1:0]  gnt_ch, take_ch;
    seq_e           seq;
    step_e          step;
    logic [1:0]     t_hit;
    logic [CW-1:0]  t_idx [2];
    logic [NCH-1:0] t_req [2];

    // one request latch and overrun detector per channel
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rxs_req_latch #(.FIFO_BLKS(FIFO_BLKS), .LW(LW)) u_lat (
            .clk  (clk),
            .rst  (rst),
            .lvl  (lvl_i[c*LW +: LW]),
            .xfer (xfer_i[c*LW +: LW]),
            .wr   (wr_i[c]),
            .busy (active && (seq != SEQ_CACHE) && (int'(gnt_ch) == c)),
            .take (take && (int'(take_ch) == c)),
            .pend (pend[c]),
            .ovr  (ovr_o[c])
        );
    end

    assign t_req[0] = pend & prio_i;
    assign t_req[1] = pend & ~prio_i;

    // tier 0 of this pair holds priority channels, tier 1 the rest
    for (genvar t = 0; t < 2; t++) begin : g_tier
        rxs_rr_arb #(.N(NCH), .CW(CW)) u_arb (
            .clk     (clk),
            .rst     (rst),
            .req     (t_req[t]),
            .adv     (fin && (fin_prio == (t == 0))),
            .adv_idx (gnt_ch),
            .hit     (t_hit[t]),
            .idx     (t_idx[t])
        );
    end

    rxs_seq_fsm #(.NCH(NCH), .CW(CW), .REFILL_EVERY(REFILL_EVERY)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .refill_req (refill_req_i),
        .p_hit      (t_hit[0]),
        .p_idx      (t_idx[0]),
        .n_hit      (t_hit[1]),
        .n_idx      (t_idx[1]),
        .sop        (sop_i),
        .eop        (eop_i),
        .txn_done   (txn_done_i),
        .tx_req     (tx_req_i),
        .tx_done    (tx_done_i),
        .active     (active),
        .gnt_ch     (gnt_ch),
        .seq        (seq),
        .step       (step),
        .txn_valid  (txn_valid_o),
        .tx_gnt     (tx_gnt_o),
        .take       (take),
        .take_ch    (take_ch),
        .fin        (fin),
        .fin_prio   (fin_prio)
    );

    assign gnt_valid_o = active;
    assign gnt_ch_o    = gnt_ch;
    assign seq_o       = seq;
    assign step_o      = step;
endmodule

// File: rtl/rxdma_sched_chk.sv
module rxdma_sched_chk #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] wr_i,
    input logic           txn_done_i,
    input logic           tx_req_i,
    input logic           gnt_valid_o,
    input logic [CW-1:0]  gnt_ch_o,
    input logic [2:0]     seq_o,
    input logic [2:0]     step_o,
    input logic           txn_valid_o,
    input logic           tx_gnt_o,
    input logic [NCH-1:0] ovr_o
);
    // R7
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid_o && !(txn_valid_o && txn_done_i)) |=>
            (gnt_valid_o && $stable(gnt_ch_o) && $stable(seq_o)));

    // R8
    gap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_gnt_o && txn_valid_o));

    // R8
    gap_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_gnt_o) |-> $past(txn_done_i && tx_req_i && txn_valid_o));

    // R4
    fetch_in_sop_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_valid_o && step_o == 3'd2) |-> (seq_o == 3'd2));

    // R5
    eop_steps_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_valid_o && step_o >= 3'd5) |-> (seq_o == 3'd4));

    // R9
    ovr_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|ovr_o) |-> $past(|wr_i));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !gnt_valid_o |-> (!txn_valid_o && !tx_gnt_o));
endmodule

bind rxdma_sched rxdma_sched_chk #(.NCH(NCH), .CW(CW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (wr_i),
    .txn_done_i  (txn_done_i),
    .tx_req_i    (tx_req_i),
    .gnt_valid_o (gnt_valid_o),
    .gnt_ch_o    (gnt_ch_o),
    .seq_o       (seq_o),
    .step_o      (step_o),
    .txn_valid_o (txn_valid_o),
    .tx_gnt_o    (tx_gnt_o),
    .ovr_o       (ovr_o)
);

// File: tb/rxdma_sched_tb_top.sv
module rxdma_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int FIFO_BLKS = 15;
    localparam int LW = 4;
    localparam int CW = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic [NCH*LW-1:0] lvl, xfer;
    logic [NCH-1:0]    sop, eop, prio, wr;
    logic              refill, done, txreq, txdone;
    logic              gv, tv, tg;
    logic [CW-1:0]     gch;
    logic [2:0]        sq, stp;
    logic [NCH-1:0]    ovr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    rxdma_sched #(.NCH(NCH), .FIFO_BLKS(FIFO_BLKS), .REFILL_EVERY(6)) dut_i (
        .clk(clk), .rst(rst), .lvl_i(lvl), .xfer_i(xfer), .sop_i(sop), .eop_i(eop),
        .prio_i(prio), .wr_i(wr), .refill_req_i(refill), .txn_done_i(done),
        .tx_req_i(txreq), .tx_done_i(txdone), .gnt_valid_o(gv), .gnt_ch_o(gch),
        .seq_o(sq), .step_o(stp), .txn_valid_o(tv), .tx_gnt_o(tg), .ovr_o(ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // vector: req mask, prio, sop, eop, refill | exp valid, ch, seq, step, requirement
    typedef struct packed {
        logic [3:0] msk;
        logic [3:0] pri;
        logic [3:0] so;
        logic [3:0] eo;
        logic       rf;
        logic       ev;
        logic [1:0] ech;
        logic [2:0] eseq;
        logic [2:0] estp;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 4'b0000, 4'b0001, 4'b0000, 1'b0, 1'b1, 2'd0, 3'd2, 3'd2, 4'd4}, // R4
        '{4'b0110, 4'b0100, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd2, 3'd3, 3'd4, 4'd2}, // R2
        '{4'b1000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd0, 3'd1, 3'd1, 4'd2}, // R2
        '{4'b1010, 4'b0000, 4'b0000, 4'b1000, 1'b0, 1'b1, 2'd1, 3'd3, 3'd4, 4'd3}, // R3
        '{4'b1010, 4'b1000, 4'b0000, 4'b1000, 1'b0, 1'b1, 2'd3, 3'd4, 3'd5, 4'd5}, // R5
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 4'd1}, // R1
        '{4'b0100, 4'b0000, 4'b0100, 4'b0100, 1'b0, 1'b1, 2'd2, 3'd4, 3'd5, 4'd6}, // R6
        '{4'b0011, 4'b0011, 4'b0010, 4'b0000, 1'b0, 1'b1, 2'd0, 3'd3, 3'd4, 4'd3}  // R3
    };

    task automatic chk(input logic ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
        end
    endtask

    task automatic set_lvl(input int c, input int v);
        lvl[c*LW +: LW] = LW'(v);
    endtask

    task automatic do_reset();
        rst = 1'b1; lvl = '0; sop = '0; eop = '0; prio = '0; wr = '0;
        refill = 1'b0; done = 1'b0; txreq = 1'b0; txdone = 1'b0;
        for (int c = 0; c < NCH; c++) xfer[c*LW +: LW] = LW'(2);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_grant(input int lim);
        for (int i = 0; i < lim && !gv; i++) @(negedge clk);
    endtask

    task automatic pulse_done();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic finish_seq();
        for (int i = 0; i < 8 && gv; i++) pulse_done();
    endtask

    initial begin
        do_reset();
        // R10 reset state
        chk(!gv && !tv && !tg, "R10", int'(gv), 0);
        chk(ovr == '0, "R10", int'(ovr), 0);

        // table walk, each vector from reset
        for (int v = 0; v < NV; v++) begin
            do_reset();
            for (int c = 0; c < NCH; c++) set_lvl(c, VECS[v].msk[c] ? 2 : 0);
            prio = VECS[v].pri; sop = VECS[v].so; eop = VECS[v].eo; refill = VECS[v].rf;
            wait_grant(5);
            chk(gv == VECS[v].ev, $sformatf("R%0d valid", VECS[v].rq), int'(gv), int'(VECS[v].ev));
            if (VECS[v].ev) begin
                chk(gch == VECS[v].ech, $sformatf("R%0d ch", VECS[v].rq), int'(gch), int'(VECS[v].ech));
                chk(sq == VECS[v].eseq, $sformatf("R%0d seq", VECS[v].rq), int'(sq), int'(VECS[v].eseq));
                chk(stp == VECS[v].estp, $sformatf("R%0d step", VECS[v].rq), int'(stp), int'(VECS[v].estp));
            end
            refill = 1'b0; lvl = '0;
            finish_seq();
        end

        // R3 rotation with all channels requesting, no flags
        do_reset();
        for (int c = 0; c < NCH; c++) set_lvl(c, 2);
        for (int n = 0; n < 5; n++) begin
            wait_grant(6);
            chk(gv && gch == CW'(n % NCH), "R3 rotation", int'(gch), n % NCH);
            finish_seq();
        end

        // R7 R8 R1 atomic start series with transmit gap and a one-cycle rival
        do_reset();
        set_lvl(0, 2); sop = 4'b0001; prio = 4'b0010;
        wait_grant(5);
        chk(stp == 3'd2, "R4 first fetch", int'(stp), 2);
        txreq = 1'b1; set_lvl(1, 2);
        pulse_done();
        set_lvl(1, 0);
        chk(tg && !tv, "R8 gap entered", int'(tg), 1);
        chk(stp == 3'd3, "R8 next step shown", int'(stp), 3);
        repeat (2) @(negedge clk);
        chk(gv && gch == 2'd0, "R7 held", int'(gch), 0);
        txreq = 1'b0; txdone = 1'b1;
        @(negedge clk);
        txdone = 1'b0;
        chk(tv && !tg && stp == 3'd3, "R8 resume", int'(stp), 3);
        pulse_done();
        chk(stp == 3'd4 && tv, "R4 data step", int'(stp), 4);
        pulse_done();
        chk(!gv, "R4 release", int'(gv), 0);
        set_lvl(0, 0);
        wait_grant(4);
        chk(gv && gch == 2'd1, "R1 held request", int'(gch), 1);
        finish_seq();

        // R4 fetch on every sixth start
        do_reset();
        set_lvl(0, 2); sop = 4'b0001;
        for (int n = 0; n < 7; n++) begin
            wait_grant(6);
            chk(stp == ((n % 6 == 0) ? 3'd2 : 3'd3), "R4 sixth start", int'(stp), (n % 6 == 0) ? 2 : 3);
            finish_seq();
        end

        // R5 end series order
        do_reset();
        set_lvl(2, 2); eop = 4'b0100;
        wait_grant(5);
        set_lvl(2, 0);
        chk(stp == 3'd5, "R5 tail", int'(stp), 5);
        pulse_done();
        chk(stp == 3'd6, "R5 desc", int'(stp), 6);
        pulse_done();
        chk(stp == 3'd7 && gv, "R5 post", int'(stp), 7);
        pulse_done();
        chk(!gv, "R5 release", int'(gv), 0);

        // R9 overrun
        do_reset();
        set_lvl(1, FIFO_BLKS); wr = 4'b0010;
        @(negedge clk);
        wr = '0;
        chk(ovr == 4'b0010, "R9 full", int'(ovr), 2);
        set_lvl(1, FIFO_BLKS - 1); wr = 4'b0010;
        @(negedge clk);
        wr = '0;
        chk(ovr == 4'b0000, "R9 not full", int'(ovr), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule